// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address, made of a 16-bit segment selector and an offset, into a linear address. It has two modes, chosen for each request. In real mode the segment value is scaled by sixteen and added to a 16-bit offset, which gives a 20-bit address. In protected mode the selector picks a descriptor from one of two small internal tables, one global and one local. The block checks the offset and the access kind against that descriptor and adds the descriptor's base address to the offset.

Software or a boot sequencer fills the tables through a single write port. Requests go through a two-stage pipeline. The block accepts one request per cycle and returns each answer a fixed two cycles later, flagged either as a valid address or as a fault.

Top module: `segXlate`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `rspValid` high for exactly one cycle, after the second rising edge that follows. Requests on consecutive cycles each get their own response, in order. With no request, `rspValid` stays low.
- R2: When `reqProt` is 0 (real mode), `rspLinear` equals `({reqSel,4'b0} + reqOffset[15:0])` truncated to 20 bits. The carry out of bit 19 is dropped. Bits 31:20 are zero, `reqOffset[31:16]` is ignored, and `rspFault` is 0.
- R3: In protected mode, `reqSel[15:3]` is the table index and `reqSel[2]` selects the table (0 global, 1 local). `reqSel[1:0]` has no effect on the result.
- R4: A descriptor is 64 bits. Bits 31:0 hold the base. Bits 51:32 hold the limit. Bit 52 is the granularity flag, bit 53 marks a code segment, bit 54 marks the segment writable, and bits 63:55 are unused. A protected-mode response that does not fault returns `base + reqOffset` modulo 2^32.
- R5: The effective limit is `{limit,12'hFFF}` when the granularity flag is 1, and the zero-extended limit otherwise. An offset greater than the effective limit faults. An offset equal to it does not.
- R6: A protected-mode request with `reqWrite` = 1 faults when the descriptor marks a code segment or is not writable. Reads of such segments are not refused on that ground.
- R7: A protected-mode index of `TABLE_DEPTH` or more faults, whatever the table contents.
- R8: A faulting response drives `rspLinear` to zero.
- R9: A lookup sampled at the same edge as a table write to the same entry uses the entry's previous contents. The next lookup sees the new contents. A write to one table leaves the other table unchanged.
- R10: Reset clears `rspValid` and fills both tables with all-zero descriptors. A zero descriptor is a byte-granular, read-only data segment with base 0 and limit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrLocal | input | 1 | Write target: 0 global table, 1 local table |
| tblWrIdx | input | IDX_W | Entry index to write |
| tblWrData | input | 64 | Descriptor to write |
| reqValid | input | 1 | Translation request strobe |
| reqProt | input | 1 | 1 protected mode, 0 real mode |
| reqWrite | input | 1 | Access is a write |
| reqSel | input | 16 | Segment selector or real-mode segment |
| reqOffset | input | 32 | Offset |
| rspValid | output | 1 | Response strobe |
| rspFault | output | 1 | Response is a fault |
| rspLinear | output | 32 | Linear address (zero on fault) |

## Verification
The two functions that can coincide are a table write and a protected-mode lookup that lands on the same entry in the same cycle. The bench provokes this with directed steps that write a new descriptor while looking up that entry, then look it up again one cycle later. The bench also mixes random writes and random lookups on every cycle of the random phase. Its model builds each expected result from the table contents as they stood before that cycle's write, so the overlapping lookup must return the old mapping and the following one the new.

// File: rtl/segXlatePkg.sv
package segXlatePkg;

  localparam int SEL_W   = 16;
  localparam int OFF_W   = 32;
  localparam int LIN_W   = 32;
  localparam int REAL_W  = 20;
  localparam int LIMIT_W = 20;
  localparam int DESC_W  = 64;
  localparam int IDXF_W  = SEL_W - 3;

  // Descriptor, most significant field first.
  typedef struct packed {
    logic [8:0]         rsvd;
    logic               writable;
    logic               isCode;
    logic               gran;
    logic [LIMIT_W-1:0] limit;
    logic [LIN_W-1:0]   base;
  } descT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } strobeT;

endpackage

// File: rtl/segXlateCtrl.sv
module segXlateCtrl
  import segXlatePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  output strobeT strobes,
  output logic   rspValid
);

  logic s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      s1Valid  <= reqValid;
      rspValid <= s1Valid;
    end
  end

  assign strobes.loadStage1 = reqValid;
  assign strobes.loadStage2 = s1Valid;

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##2 rspValid); // R1

  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> rspValid); // R1

endmodule

// File: rtl/segXlateDatapath.sv
module segXlateDatapath
  import segXlatePkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic              tblWrEn,
  input  logic              tblWrLocal,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  descT              tblWrDesc,
  input  logic              reqProt,
  input  logic              reqWrite,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [OFF_W-1:0]  reqOffset,
  output logic              rspFault,
  output logic [LIN_W-1:0]  rspLinear
);

  // Selector decode: index, table pick; low two bits unused.
  logic [IDXF_W-1:0] selIdx;
  logic              selLocal;
  logic              idxBad;
  logic [IDX_W-1:0]  rdIdx;

  assign selIdx   = reqSel[SEL_W-1:3];
  assign selLocal = reqSel[2];
  assign idxBad   = selIdx >= IDXF_W'(DEPTH);
  assign rdIdx    = idxBad ? '0 : IDX_W'(selIdx);

  descT pick [2];

  // One descriptor store per table.
  for (genvar t = 0; t < 2; t++) begin : gTable
    descT entries [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
      end else if (tblWrEn && (tblWrLocal == t[0]) && (32'(tblWrIdx) < DEPTH)) begin
        entries[tblWrIdx] <= tblWrDesc;
      end
    end

    assign pick[t] = entries[rdIdx];
  end

  // Stage 1: capture request and the descriptor as it stood before this edge.
  logic             s1Prot;
  logic             s1Write;
  logic             s1IdxBad;
  logic [SEL_W-1:0] s1Seg;
  logic [OFF_W-1:0] s1Offset;
  descT             s1Desc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Prot   <= 1'b0;
      s1Write  <= 1'b0;
      s1IdxBad <= 1'b0;
      s1Seg    <= '0;
      s1Offset <= '0;
      s1Desc   <= '0;
    end else if (strobes.loadStage1) begin
      s1Prot   <= reqProt;
      s1Write  <= reqWrite;
      s1IdxBad <= idxBad;
      s1Seg    <= reqSel;
      s1Offset <= reqOffset;
      s1Desc   <= pick[selLocal];
    end
  end

  // Stage 2: compute address and fault.
  logic [REAL_W-1:0] realSum;
  logic [LIN_W-1:0]  effLimit;
  logic              limitFault;
  logic              rightsFault;
  logic              protFault;
  logic [LIN_W-1:0]  nextLinear;

  assign realSum     = {s1Seg, 4'b0000} + {4'b0000, s1Offset[15:0]};
  assign effLimit    = s1Desc.gran ? {s1Desc.limit, 12'hFFF}
                                   : {{(LIN_W-LIMIT_W){1'b0}}, s1Desc.limit};
  assign limitFault  = s1Offset > effLimit;
  assign rightsFault = s1Write && (s1Desc.isCode || !s1Desc.writable);
  assign protFault   = s1Prot && (s1IdxBad || limitFault || rightsFault);

  always_comb begin
    if (!s1Prot)        nextLinear = {{(LIN_W-REAL_W){1'b0}}, realSum};
    else if (protFault) nextLinear = '0;
    else                nextLinear = s1Desc.base + s1Offset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspFault  <= 1'b0;
      rspLinear <= '0;
    end else if (strobes.loadStage2) begin
      rspFault  <= protFault;
      rspLinear <= nextLinear;
    end
  end

  AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStage2 && !s1Prot) |=> !rspFault); // R2

  AST_REAL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStage2 && !s1Prot) |=> (rspLinear[LIN_W-1:REAL_W] == '0)); // R2

  AST_BAD_INDEX_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStage2 && s1Prot && s1IdxBad) |=> rspFault); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStage2 && s1Prot) |=> (!rspFault || rspLinear == '0)); // R8

  AST_WRITE_RIGHTS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStage2 && s1Prot && s1Write && s1Desc.isCode) |=> rspFault); // R6

endmodule

// File: rtl/segXlate.sv
module segXlate
  import segXlatePkg::*;
#(
  parameter int TABLE_DEPTH = 8,
  localparam int IDX_W = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tblWrEn,
  input  logic             tblWrLocal,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [63:0]      tblWrData,
  input  logic             reqValid,
  input  logic             reqProt,
  input  logic             reqWrite,
  input  logic [15:0]      reqSel,
  input  logic [31:0]      reqOffset,
  output logic             rspValid,
  output logic             rspFault,
  output logic [31:0]      rspLinear
);

  strobeT strobes;
  descT   wrDesc;

  assign wrDesc = descT'(tblWrData);

  segXlateCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  segXlateDatapath #(.DEPTH(TABLE_DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tblWrEn    (tblWrEn),
    .tblWrLocal (tblWrLocal),
    .tblWrIdx   (tblWrIdx),
    .tblWrDesc  (wrDesc),
    .reqProt    (reqProt),
    .reqWrite   (reqWrite),
    .reqSel     (reqSel),
    .reqOffset  (reqOffset),
    .rspFault   (rspFault),
    .rspLinear  (rspLinear)
  );

endmodule

// File: tb/tb_segXlate.sv
`timescale 1ns/1ps
module tb_segXlate;

  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          tblWrEn, tblWrLocal;
  logic [IW-1:0] tblWrIdx;
  logic [63:0]   tblWrData;
  logic          reqValid, reqProt, reqWrite;
  logic [15:0]   reqSel;
  logic [31:0]   reqOffset;
  logic          rspValid, rspFault;
  logic [31:0]   rspLinear;

  always #2.5 clk = ~clk;

  segXlate #(.TABLE_DEPTH(DEPTH)) dut (.*);

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  logic [63:0] mTbl [2][DEPTH];

  // Expected-result pipeline: slot 0 = last cycle, slot 1 = two cycles back.
  bit          pV [2];
  bit          pF [2];
  logic [31:0] pL [2];
  string       pTag [2];

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input bit gran, input bit code, input bit wrt);
    return {9'b0, wrt, code, gran, lim, base};
  endfunction

  function automatic void calc(input bit prot, input bit wr, input logic [15:0] sel,
                               input logic [31:0] off, output bit f, output logic [31:0] lin);
    logic [19:0] s;
    logic [63:0] d;
    logic [31:0] eff;
    int idx;
    if (!prot) begin
      s = {sel, 4'b0} + {4'b0, off[15:0]};
      lin = {12'b0, s};
      f = 1'b0;
    end else begin
      idx = int'(sel[15:3]);
      if (idx >= DEPTH) f = 1'b1;
      else begin
        d = mTbl[sel[2]][idx];
        eff = d[52] ? {d[51:32], 12'hFFF} : {12'b0, d[51:32]};
        f = (off > eff) || (wr && (d[53] || !d[54]));
      end
      lin = f ? 32'h0 : (d[31:0] + off);
    end
  endfunction

  task automatic checkOut();
    nChecks++;
    if (rspValid !== pV[1]) begin
      nErrors++;
      $display("FAIL %s rspValid actual=%0b expected=%0b", pV[1] ? pTag[1] : "R1", rspValid, pV[1]);
    end else if (pV[1]) begin
      nChecks++;
      if (rspFault !== pF[1] || rspLinear !== pL[1]) begin
        nErrors++;
        $display("FAIL %s fault/linear actual=%0b/%h expected=%0b/%h",
                 pTag[1], rspFault, rspLinear, pF[1], pL[1]);
      end
    end
  endtask

  task automatic step(input bit rv, input bit prot, input bit wr, input logic [15:0] sel,
                      input logic [31:0] off, input bit we, input bit wl,
                      input logic [IW-1:0] wi, input logic [63:0] wd, input string tag);
    bit f;
    logic [31:0] lin;
    @(negedge clk);
    checkOut();
    pV[1] = pV[0]; pF[1] = pF[0]; pL[1] = pL[0]; pTag[1] = pTag[0];
    calc(prot, wr, sel, off, f, lin);
    pV[0] = rv; pF[0] = f; pL[0] = lin; pTag[0] = tag;
    reqValid = rv; reqProt = prot; reqWrite = wr; reqSel = sel; reqOffset = off;
    tblWrEn = we; tblWrLocal = wl; tblWrIdx = wi; tblWrData = wd;
    if (we) mTbl[wl][wi] = wd;   // applied after the lookup model (R9)
  endtask

  task automatic look(input bit prot, input bit wr, input logic [15:0] sel,
                      input logic [31:0] off, input string tag);
    step(1'b1, prot, wr, sel, off, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic put(input bit wl, input logic [IW-1:0] wi, input logic [63:0] wd);
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, wl, wi, wd, "R1");
  endtask

  function automatic logic [15:0] sl(input int idx, input bit loc, input logic [1:0] lo);
    return {13'(idx), loc, lo};
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) mTbl[t][i] = '0;
    for (int i = 0; i < 2; i++) begin pV[i] = 0; pF[i] = 0; pL[i] = 0; pTag[i] = "R1"; end
    rstN = 0; tblWrEn = 0; tblWrLocal = 0; tblWrIdx = '0; tblWrData = '0;
    reqValid = 0; reqProt = 0; reqWrite = 0; reqSel = '0; reqOffset = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (rspValid !== 1'b0) begin
      nErrors++;
      $display("FAIL R10 rspValid in reset actual=%0b expected=0", rspValid);
    end
    rstN = 1;

    // R10: cleared tables give base 0, limit 0, read-only data
    look(1, 0, sl(0, 0, 0), 32'h0, "R10");
    look(1, 0, sl(5, 1, 0), 32'h1, "R10");
    look(1, 1, sl(0, 0, 0), 32'h0, "R10");

    // R2: real mode, wrap and ignored upper offset bits
    look(0, 0, 16'hA1F0, 32'h0000_04C0, "R2");
    look(0, 1, 16'hFFFF, 32'hABCD_FFFF, "R2");
    look(0, 0, 16'h028F, 32'h0000_0030, "R2");

    // R4/R5/R3: byte-granular data segment in global table
    put(0, 3'd1, mk(32'h1000_0000, 20'h00FFF, 0, 0, 1));
    look(1, 0, sl(1, 0, 2'b11), 32'h0000_0FFF, "R5");
    look(1, 0, sl(1, 0, 2'b01), 32'h0000_1000, "R5");
    look(1, 1, sl(1, 0, 2'b10), 32'h0000_0010, "R4");

    // R5/R3: page-granular segment in local table, same index
    put(1, 3'd1, mk(32'h2000_0000, 20'h00001, 1, 0, 1));
    look(1, 0, sl(1, 1, 0), 32'h0000_1FFF, "R5");
    look(1, 0, sl(1, 1, 3), 32'h0000_2000, "R5");
    look(1, 0, sl(1, 0, 0), 32'h0000_0004, "R3");

    // R6: code and read-only segments
    put(0, 3'd2, mk(32'h3000_0000, 20'hFFFFF, 0, 1, 1));
    put(0, 3'd3, mk(32'h4000_0000, 20'hFFFFF, 0, 0, 0));
    look(1, 0, sl(2, 0, 0), 32'h0000_0100, "R6");
    look(1, 1, sl(2, 0, 0), 32'h0000_0100, "R6");
    look(1, 0, sl(3, 0, 0), 32'h0000_0200, "R6");
    look(1, 1, sl(3, 0, 0), 32'h0000_0200, "R6");

    // R7: index out of range
    look(1, 0, sl(DEPTH, 0, 0), 32'h0, "R7");
    look(1, 0, 16'hFFFF, 32'h0, "R7");

    // R4: base plus offset wraps at 32 bits
    put(1, 3'd7, mk(32'hFFFF_F000, 20'hFFFFF, 1, 0, 1));
    look(1, 1, sl(7, 1, 0), 32'h0000_2000, "R4");

    // R9: write and lookup of the same entry in one cycle, then again
    step(1, 1, 0, sl(1, 0, 0), 32'h0000_0020, 1, 0, 3'd1,
         mk(32'h5000_0000, 20'h000FF, 0, 0, 1), "R9");
    look(1, 0, sl(1, 0, 0), 32'h0000_0020, "R9");
    look(1, 0, sl(1, 1, 0), 32'h0000_0020, "R9");

    // R1: back-to-back random stream with random table writes
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      logic [15:0] s;
      logic [31:0] o;
      logic [19:0] lm;
      lm = 20'($urandom_range(0, 3)) << ($urandom_range(0, 4) * 4);
      d = mk($urandom, lm, 1'($urandom), 1'($urandom), 1'($urandom));
      s = sl($urandom_range(0, DEPTH + 1), 1'($urandom), 2'($urandom));
      o = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 32'h4FFF)) : $urandom;
      if ($urandom_range(0, 3) == 0) s = 16'($urandom);
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), 1'($urandom),
           s, o, 1'($urandom_range(0, 2) == 0), 1'($urandom), 3'($urandom), d, "R1");
    end

    step(0, 0, 0, '0, '0, 0, 0, '0, '0, "R1");
    step(0, 0, 0, '0, '0, 0, 0, '0, '0, "R1");
    step(0, 0, 0, '0, '0, 0, 0, '0, '0, "R1");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule